// File: doc/BRIEF.md
# Transactional Register Snapshot Manager

This block keeps the register state that an out-of-order core needs in order to roll back a transaction. It holds the current rename table, which maps each architectural register to a physical register. Beside the table it keeps a saved bit for each physical register, marking the registers that the table currently names. When a transaction begin is decoded, the block copies the table and the saved bits into a small pending queue. A copy becomes the active snapshot only when the same begin instruction retires, so several transactions can be in flight while only one of them pins registers.

While a snapshot is active, a retire-time request to free a physical register in that snapshot's saved set does not release the register. The register goes to a reserved list, because an abort may still need it. When a transaction end retires, the reserved list is released and the active snapshot is dropped. An abort puts the active snapshot's mapping back into the table and reports the mapping on the restore outputs. It also empties the pending queue and clears the reserved list. Since only one snapshot pins registers, the number held back never exceeds the architectural register count.

Top module: `txsnap_mgr`

## Requirements
- R1: After reset, architectural register i maps to physical register i, the saved set is physical registers 0 to NARCH-1, `free_mask` and `restore_valid` are 0, and `dec_full` is 0.
- R2: A rename writes the new physical register into the table for its architectural register, sets that register's saved bit and clears the saved bit of the register it replaces, so exactly NARCH saved bits stay set.
- R3: A decode begin copies the table and saved bits as they stand before any rename in the same cycle into a pending queue of depth PEND (2). `dec_full` is 1 while the queue holds PEND entries, and a decode begin while full is dropped.
- R4: A retire begin moves the oldest pending copy into the active snapshot. A retire begin with an empty queue does nothing, and a free made while no snapshot is active is released directly.
- R5: A retire free of physical register p appears as bit p of `free_mask` in the next cycle, unless p is in the active snapshot's saved set. In that case p goes to the reserved list and bit p stays 0.
- R6: A retire end releases the whole reserved list on `free_mask` in the next cycle, together with any free made in the same cycle, and drops the active snapshot. A retire begin in that same cycle then activates the next pending copy.
- R7: An abort with an active snapshot pulses `restore_valid` for one cycle, one cycle later. `restore_map` carries the snapshot mapping, where field i (bits i*PW to i*PW+PW-1) is the physical register of architectural register i. The abort reloads the table, flushes the pending queue, drops the active snapshot and clears the reserved list. Reserved registers that the restored table maps are not released.
- R8: An abort without an active snapshot raises no `restore_valid`, releases nothing and flushes the pending queue. Any rename, begin, end or free presented in an abort cycle is ignored.
- R9: The reserved list never holds more than NARCH registers, whatever the number of pending transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Decode-time rename strobe |
| ren_arch | input | AW | Architectural register being renamed |
| ren_phys | input | PW | New physical register for it |
| dec_begin | input | 1 | Transaction begin decoded |
| dec_full | output | 1 | Pending queue full; decode must stall begins |
| ret_begin | input | 1 | Transaction begin retired |
| ret_end | input | 1 | Transaction end retired |
| ret_free_valid | input | 1 | Retire-time free request |
| ret_free_phys | input | PW | Physical register to free |
| abort | input | 1 | Abort strobe |
| free_mask | output | NPHYS | One bit per physical register released this cycle |
| restore_valid | output | 1 | Restored mapping is valid this cycle |
| restore_map | output | NARCH*PW | Restored mapping, PW bits per architectural register |

## Verification
Two functions can fall on the same cycle: a retire-time free of a register in the saved set, which diverts it, and a transaction end, which releases the reserved list. The bench presents a free of a saved register in the same cycle as the end. It expects that register to appear in the next `free_mask` alongside the previously reserved ones. A second case pairs an end with a retire begin. The bench checks that the old list is released and that a later free of a register in the new snapshot is held back again.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int TSM_NARCH = 4;
  localparam int TSM_NPHYS = 16;
  localparam int TSM_PEND  = 2;
endpackage

// File: rtl/tsm_map.sv
module tsm_map #(
  parameter int NARCH = 4,
  parameter int NPHYS = 16,
  localparam int PW = $clog2(NPHYS),
  localparam int AW = $clog2(NARCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rename_en,
  input  logic [AW-1:0]         rename_arch,
  input  logic [PW-1:0]         rename_phys,
  input  logic                  restore_en,
  input  logic [NARCH*PW-1:0]   restore_tbl,
  input  logic [NPHYS-1:0]      restore_saved,
  output logic [NARCH*PW-1:0]   map_q,
  output logic [NPHYS-1:0]      saved_q
);
  function automatic logic [NARCH*PW-1:0] ident_map();
    logic [NARCH*PW-1:0] m;
    for (int i = 0; i < NARCH; i++) m[i*PW +: PW] = PW'(i);
    return m;
  endfunction

  function automatic logic [NPHYS-1:0] ident_saved();
    logic [NPHYS-1:0] s;
    s = '0;
    for (int i = 0; i < NARCH; i++) s[i] = 1'b1;
    return s;
  endfunction

  logic [PW-1:0] old_phys;
  assign old_phys = map_q[rename_arch*PW +: PW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q   <= ident_map();
      saved_q <= ident_saved();
    end else if (restore_en) begin
      map_q   <= restore_tbl;
      saved_q <= restore_saved;
    end else if (rename_en) begin
      saved_q[old_phys]                <= 1'b0;
      saved_q[rename_phys]             <= 1'b1;
      map_q[rename_arch*PW +: PW]      <= rename_phys;
    end
  end

  p_saved_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(saved_q) == NARCH);

  p_rename_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rename_en && !restore_en) |=> saved_q[$past(rename_phys)]);
endmodule

// File: rtl/tsm_pend.sv
module tsm_pend #(
  parameter int W     = 32,
  parameter int DEPTH = 2,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         head_valid,
  output logic         full
);
  logic [W-1:0]    slot [DEPTH];
  logic [PTRW-1:0] rd_p, wr_p;
  logic [CW-1:0]   cnt;
  logic            do_push, do_pop;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full       = (cnt == CW'(DEPTH));
  assign head_valid = (cnt != '0);
  assign head       = slot[rd_p];
  assign do_push    = push && !full && !flush;
  assign do_pop     = pop && head_valid && !flush;

  always_ff @(posedge clk) begin
    if (do_push) slot[wr_p] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_p <= '0;
      wr_p <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wr_p <= bump(wr_p);
      if (do_pop)  rd_p <= bump(rd_p);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_depth_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> full);
endmodule

// File: rtl/tsm_hold.sv
module tsm_hold #(
  parameter int NARCH = 4,
  parameter int NPHYS = 16,
  localparam int PW = $clog2(NPHYS),
  localparam int SW = NARCH*PW + NPHYS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SW-1:0]       load_snap,
  input  logic                end_tx,
  input  logic                abort,
  input  logic                free_req,
  input  logic [PW-1:0]       free_phys,
  output logic                act_valid,
  output logic [NARCH*PW-1:0] act_map,
  output logic [NPHYS-1:0]    act_saved,
  output logic [NPHYS-1:0]    free_mask
);
  function automatic logic [NPHYS-1:0] map_mask(input logic [NARCH*PW-1:0] m);
    logic [NPHYS-1:0] r;
    r = '0;
    for (int i = 0; i < NARCH; i++) r[m[i*PW +: PW]] = 1'b1;
    return r;
  endfunction

  logic [NPHYS-1:0] reserved, res_n, free_n, req_bit;
  logic             act_v_n, divert;

  assign divert  = free_req && act_valid && act_saved[free_phys];
  assign req_bit = free_req ? (NPHYS'(1) << free_phys) : '0;

  always_comb begin
    res_n   = reserved;
    free_n  = '0;
    act_v_n = act_valid;
    if (abort) begin
      free_n  = reserved & ~map_mask(act_map);
      res_n   = '0;
      act_v_n = 1'b0;
    end else begin
      if (divert) res_n  = reserved | req_bit;
      else        free_n = req_bit;
      if (end_tx) begin
        free_n  = free_n | res_n;
        res_n   = '0;
        act_v_n = 1'b0;
      end
      if (load) act_v_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reserved  <= '0;
      free_mask <= '0;
      act_valid <= 1'b0;
      act_map   <= '0;
      act_saved <= '0;
    end else begin
      reserved  <= res_n;
      free_mask <= free_n;
      act_valid <= act_v_n;
      if (load && !abort) {act_map, act_saved} <= load_snap;
    end
  end

  p_reserved_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(reserved) <= NARCH);

  p_reserve_needs_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reserved != '0) |-> act_valid);

  p_divert_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (divert && !abort && !end_tx) |=> !free_mask[$past(free_phys)]);

  p_end_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_tx && !abort) |=> (reserved == '0));
endmodule

// File: rtl/txsnap_mgr.sv
module txsnap_mgr import tsm_pkg::*; #(
  parameter int NARCH = TSM_NARCH,
  parameter int NPHYS = TSM_NPHYS,
  parameter int PEND  = TSM_PEND,
  localparam int PW = $clog2(NPHYS),
  localparam int AW = $clog2(NARCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ren_valid,
  input  logic [AW-1:0]       ren_arch,
  input  logic [PW-1:0]       ren_phys,
  input  logic                dec_begin,
  output logic                dec_full,
  input  logic                ret_begin,
  input  logic                ret_end,
  input  logic                ret_free_valid,
  input  logic [PW-1:0]       ret_free_phys,
  input  logic                abort,
  output logic [NPHYS-1:0]    free_mask,
  output logic                restore_valid,
  output logic [NARCH*PW-1:0] restore_map
);
  localparam int SW = NARCH*PW + NPHYS;

  logic [NARCH*PW-1:0] map_q, act_map;
  logic [NPHYS-1:0]    saved_q, act_saved;
  logic [SW-1:0]       pend_head;
  logic                pend_valid, act_valid;
  logic                ren_go, push_go, pop_go, act_load, restore_go;

  assign ren_go     = ren_valid & ~abort;
  assign push_go    = dec_begin & ~abort;
  assign pop_go     = ret_begin & ~abort;
  assign act_load   = pop_go & pend_valid;
  assign restore_go = abort & act_valid;

  tsm_map #(.NARCH(NARCH), .NPHYS(NPHYS)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rename_en(ren_go), .rename_arch(ren_arch), .rename_phys(ren_phys),
    .restore_en(restore_go), .restore_tbl(act_map), .restore_saved(act_saved),
    .map_q(map_q), .saved_q(saved_q)
  );

  tsm_pend #(.W(SW), .DEPTH(PEND)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .push(push_go), .din({map_q, saved_q}), .pop(pop_go), .flush(abort),
    .head(pend_head), .head_valid(pend_valid), .full(dec_full)
  );

  tsm_hold #(.NARCH(NARCH), .NPHYS(NPHYS)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load(act_load), .load_snap(pend_head), .end_tx(ret_end & ~abort),
    .abort(abort), .free_req(ret_free_valid), .free_phys(ret_free_phys),
    .act_valid(act_valid), .act_map(act_map), .act_saved(act_saved),
    .free_mask(free_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      restore_valid <= 1'b0;
      restore_map   <= '0;
    end else begin
      restore_valid <= restore_go;
      if (restore_go) restore_map <= act_map;
    end
  end

  p_abort_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && act_valid) |=> (restore_valid && restore_map == $past(act_map)));

  p_quiet_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !act_valid) |=> (!restore_valid && free_mask == '0));

  p_abort_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!act_valid && !dec_full));
endmodule

// File: tb/sim_txsnap_mgr.sv
module sim_txsnap_mgr;
  localparam int NA = 4;
  localparam int NP = 16;
  localparam int PW = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, dec_begin = 1'b0, ret_begin = 1'b0, ret_end = 1'b0;
  logic ret_free_valid = 1'b0, abort = 1'b0;
  logic [AW-1:0] ren_arch = '0;
  logic [PW-1:0] ren_phys = '0, ret_free_phys = '0;
  logic dec_full, restore_valid;
  logic [NP-1:0] free_mask;
  logic [NA*PW-1:0] restore_map;

  always #10 clk = ~clk;

  txsnap_mgr u0 (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_arch(ren_arch),
    .ren_phys(ren_phys), .dec_begin(dec_begin), .dec_full(dec_full),
    .ret_begin(ret_begin), .ret_end(ret_end), .ret_free_valid(ret_free_valid),
    .ret_free_phys(ret_free_phys), .abort(abort), .free_mask(free_mask),
    .restore_valid(restore_valid), .restore_map(restore_map)
  );

  int total = 0, failed = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct packed { logic [NA*PW-1:0] m; logic [NP-1:0] s; } snap_t;
  typedef struct { int due; string tag; logic [NP-1:0] fm; bit full; bit rv; logic [NA*PW-1:0] rm; } exp_t;

  exp_t sb[$];
  snap_t pq[$];
  snap_t act;
  bit av = 1'b0;
  logic [NA*PW-1:0] mm;
  logic [NP-1:0] ms, res;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, string what, logic [31:0] a, logic [31:0] e);
    total++;
    if (a !== e) begin
      failed++;
      $display("FAIL %s %s actual %h expected %h", tag, what, a, e);
    end
  endtask

  // monitor: pops scoreboard items once their cycle has come
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t it;
      it = sb.pop_front();
      chk(it.tag, "free_mask", 32'(free_mask), 32'(it.fm));
      chk(it.tag, "dec_full", 32'(dec_full), 32'(it.full));
      chk(it.tag, "restore_valid", 32'(restore_valid), 32'(it.rv));
      if (it.rv) chk(it.tag, "restore_map", 32'(restore_map), 32'(it.rm));
    end
  end

  function automatic logic [NP-1:0] mask_of(logic [NA*PW-1:0] m);
    logic [NP-1:0] r = '0;
    for (int i = 0; i < NA; i++) r[m[i*PW +: PW]] = 1'b1;
    return r;
  endfunction

  task automatic step(string tag, bit rv_, int ra, int rp, bit db, bit rb,
                      bit re, bit fv, int fp, bit ab);
    exp_t it;
    snap_t cur;
    logic [NP-1:0] b;
    bit full_before;
    int old;
    ren_valid = rv_; ren_arch = AW'(ra); ren_phys = PW'(rp);
    dec_begin = db; ret_begin = rb; ret_end = re;
    ret_free_valid = fv; ret_free_phys = PW'(fp); abort = ab;
    it.due = cyc + 1; it.tag = tag; it.fm = '0; it.rv = 1'b0; it.rm = '0;
    if (ab) begin
      if (av) begin
        it.rv = 1'b1; it.rm = act.m; mm = act.m; ms = act.s;
        it.fm = res & ~mask_of(act.m);
      end
      res = '0; av = 1'b0; pq.delete();
    end else begin
      cur.m = mm; cur.s = ms; full_before = (pq.size() == 2);
      b = fv ? (NP'(1) << fp) : '0;
      if (fv && av && act.s[fp]) res |= b; else it.fm = b;
      if (re) begin it.fm |= res; res = '0; av = 1'b0; end
      if (rb && pq.size() > 0) begin act = pq.pop_front(); av = 1'b1; end
      if (db && !full_before) pq.push_back(cur);
      if (rv_) begin
        old = int'(mm[ra*PW +: PW]);
        ms[old] = 1'b0; ms[rp] = 1'b1; mm[ra*PW +: PW] = PW'(rp);
      end
    end
    it.full = (pq.size() == 2);
    sb.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NA; i++) mm[i*PW +: PW] = PW'(i);
    ms = '0; for (int i = 0; i < NA; i++) ms[i] = 1'b1;
    res = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "free_mask", 32'(free_mask), 32'h0);
    chk("R1", "restore_valid", 32'(restore_valid), 32'h0);
    chk("R1", "dec_full", 32'(dec_full), 32'h0);
    //     tag   ren a  p  db rb re fv fp ab
    step("R1", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 1);   // restore shows identity
    step("R2", 1, 0, 4, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 5, 1, 0, 0, 0, 0, 0);   // snapshot taken before this rename
    step("R2", 1, 2, 6, 0, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 0, 0);   // no active: freed directly
    step("R4", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 1, 0);   // held back
    step("R5", 0, 0, 0, 0, 0, 0, 1, 2, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 9, 0);   // not saved: freed
    step("R6_R9", 0, 0, 0, 0, 0, 1, 1, 3, 0); // end with same-cycle free
    step("R6", 0, 0, 0, 0, 0, 1, 0, 0, 0);   // end with nothing active
    step("R2", 1, 3, 7, 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R3", 1, 0, 8, 1, 0, 0, 0, 0, 0);   // queue now full
    step("R3", 1, 1, 10, 1, 0, 0, 0, 0, 0);  // begin dropped while full
    step("R4", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 4, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 5, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1);   // restore 4,5,6,7 and flush
    step("R7", 0, 0, 0, 0, 1, 0, 0, 0, 0);   // queue was flushed
    step("R7", 0, 0, 0, 0, 0, 0, 1, 5, 0);   // nothing active: freed
    step("R8", 1, 0, 11, 1, 0, 0, 1, 12, 1); // quiet abort ignores all
    step("R8", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 1);   // restore shows rename was ignored
    step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 0, 1, 6, 0);
    step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 1, 1, 0, 0, 0);   // end and begin together
    step("R6", 0, 0, 0, 0, 0, 0, 1, 7, 0);   // held by new snapshot
    step("R6", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cyc > 5000) begin
      total++; failed++;
      $display("FAIL watchdog actual %0d expected <5000 cycles", cyc);
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule